// File: doc/BRIEF.md
# Speculative Load Address Check Table

This block lets a scheduler hoist loads above stores that might write the same memory. When an advanced load issues, it writes its target address and destination register number into a small fully associative table. Every later store presents its address on a snoop port. All valid entries compare against that address at once, and any entry that matches is dropped.

When the hoisted value is about to be used, a check operation looks up the destination register. The check succeeds only if a live entry for that register is still in the table. If the entry was killed by a store, or was never there because it was evicted or flushed, the check fails, and the surrounding pipeline must run recovery code. The check port is combinational. It reports against the table contents held at the start of the cycle.

Addresses are compared at a block granularity of 2^GRAN_LG2 bytes. Two accesses that fall anywhere in the same aligned block count as a conflict.

Top module: `spec_ld_check_table`

## Requirements
- R1: After reset, and in the cycle after `flush_i` is high, the table is empty and every check fails. A flush overrides an insert, store or check presented in the same cycle.
- R2: An insert of register r at address a makes a later check of r succeed, as long as no store, flush, eviction or removing check touched that entry in between.
- R3: `chk_ok_o` is high only while `chk_valid_i` is high and a valid entry holds `chk_reg_i`. `chk_fail_o` is high while `chk_valid_i` is high and no such entry exists. Both reflect the state before the current cycle's updates, and both are low when `chk_valid_i` is low.
- R4: A successful check with `chk_keep_i` low removes the entry, so the next check of that register fails. With `chk_keep_i` high the entry stays.
- R5: A store removes every valid entry whose block address matches. The block address is the address shifted right by GRAN_LG2. Entries that do not match are unaffected.
- R6: With GRAN_LG2 = 3, a store to any of the 8 bytes of an entry's aligned 8-byte block kills that entry. A store to any other block leaves it intact.
- R7: An insert for a register that already has a valid entry overwrites that entry in place, with the new address. The old address no longer matches stores.
- R8: An insert for a new register takes the lowest-index free slot. When no slot is free, it replaces the slot named by a round-robin pointer. The pointer is 0 after reset and flush-independent, and it advances by one, wrapping at NUM_ENTRIES, on each such replacement.
- R9: When a store and an insert happen in the same cycle, the inserted entry is valid afterwards, even if the store address matches it. The same holds when a removing check hits that slot in the same cycle.
- R10: No two valid entries ever hold the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drop all entries |
| ins_valid_i | input | 1 | Advanced load insert strobe |
| ins_reg_i | input | REG_W | Destination register of the advanced load |
| ins_addr_i | input | ADDR_W | Byte address of the advanced load |
| st_valid_i | input | 1 | Store snoop strobe |
| st_addr_i | input | ADDR_W | Store byte address |
| chk_valid_i | input | 1 | Check strobe |
| chk_reg_i | input | REG_W | Register being checked |
| chk_keep_i | input | 1 | Keep the entry after a successful check |
| chk_ok_o | output | 1 | Speculation still valid |
| chk_fail_o | output | 1 | Recovery required |

## Verification
The bench sweeps all 256 store addresses against one entry, which exposes a wrong granularity shift as either missed conflicts or spurious kills. It fills the table and overflows it twice. A pointer that does not start at zero, or does not advance, then evicts the wrong register and produces a check failure where a success is expected. The same-cycle store and insert case catches a design that lets the store win and loses the fresh entry. Repeated inserts to one register catch duplicate entries and a stale old address that still matches stores. A long random run against an arithmetic model covers interleavings of keep, removal, flush and overwrite.

// File: rtl/spec_chk_pkg.sv
package spec_chk_pkg;
  typedef enum logic [1:0] {
    INS_SAME_REG = 2'd0,
    INS_FREE     = 2'd1,
    INS_EVICT    = 2'd2
  } ins_kind_e;
endpackage

// File: rtl/chk_cam_match.sv
module chk_cam_match #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [W-1:0] key_i,
  input  logic [N-1:0] valid_i,
  input  logic [W-1:0] tag_i [N],
  output logic [N-1:0] hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_o[i] = valid_i[i] && (tag_i[i] == key_i);
  end
endmodule

// File: rtl/chk_slot_pick.sv
module chk_slot_pick
  import spec_chk_pkg::*;
#(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     reg_hit_i,
  input  logic [IDX_W-1:0] rr_i,
  output logic [IDX_W-1:0] slot_o,
  output ins_kind_e        kind_o
);
  always_comb begin
    slot_o = rr_i;
    kind_o = INS_EVICT;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        slot_o = IDX_W'(i);
        kind_o = INS_FREE;
      end
    end
    for (int i = 0; i < N; i++) begin
      if (reg_hit_i[i]) begin
        slot_o = IDX_W'(i);
        kind_o = INS_SAME_REG;
      end
    end
  end
endmodule

// File: rtl/spec_ld_check_table.sv
module spec_ld_check_table
  import spec_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W      = 8,
  parameter int REG_W       = 3,
  parameter int GRAN_LG2    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              ins_valid_i,
  input  logic [REG_W-1:0]  ins_reg_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic              chk_valid_i,
  input  logic [REG_W-1:0]  chk_reg_i,
  input  logic              chk_keep_i,
  output logic              chk_ok_o,
  output logic              chk_fail_o
);
  localparam int LINE_W = ADDR_W - GRAN_LG2;
  localparam int IDX_W  = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENTRIES - 1);

  logic [NUM_ENTRIES-1:0] valid_q;
  logic [REG_W-1:0]       reg_q  [NUM_ENTRIES];
  logic [LINE_W-1:0]      line_q [NUM_ENTRIES];
  logic [IDX_W-1:0]       rr_q;

  logic [NUM_ENTRIES-1:0] ins_hit, st_hit, chk_hit;
  logic [IDX_W-1:0]       ins_slot;
  ins_kind_e              ins_kind;
  logic [LINE_W-1:0]      ins_line, st_line;

  assign ins_line = ins_addr_i[ADDR_W-1:GRAN_LG2];
  assign st_line  = st_addr_i[ADDR_W-1:GRAN_LG2];

  chk_cam_match #(.N(NUM_ENTRIES), .W(REG_W)) u_ins_cam (
    .key_i(ins_reg_i), .valid_i(valid_q), .tag_i(reg_q), .hit_o(ins_hit));
  chk_cam_match #(.N(NUM_ENTRIES), .W(REG_W)) u_chk_cam (
    .key_i(chk_reg_i), .valid_i(valid_q), .tag_i(reg_q), .hit_o(chk_hit));
  chk_cam_match #(.N(NUM_ENTRIES), .W(LINE_W)) u_st_cam (
    .key_i(st_line), .valid_i(valid_q), .tag_i(line_q), .hit_o(st_hit));

  chk_slot_pick #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick (
    .valid_i(valid_q), .reg_hit_i(ins_hit), .rr_i(rr_q),
    .slot_o(ins_slot), .kind_o(ins_kind));

  assign chk_ok_o   = chk_valid_i && (chk_hit != '0);
  assign chk_fail_o = chk_valid_i && (chk_hit == '0);

  logic chk_remove;
  assign chk_remove = chk_ok_o && !chk_keep_i;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic ins_here;
    assign ins_here = ins_valid_i && (ins_slot == IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        reg_q[i]   <= '0;
        line_q[i]  <= '0;
      end else if (flush_i) begin
        valid_q[i] <= 1'b0;
      end else if (ins_here) begin
        // insert wins over same-cycle store kill or check removal
        valid_q[i] <= 1'b1;
        reg_q[i]   <= ins_reg_i;
        line_q[i]  <= ins_line;
      end else if ((st_valid_i && st_hit[i]) || (chk_remove && chk_hit[i])) begin
        valid_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (!flush_i && ins_valid_i && ins_kind == INS_EVICT) begin
      rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  assert_flush_empty_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
  assert_outputs_gated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(chk_ok_o && chk_fail_o) && ((chk_ok_o || chk_fail_o) == chk_valid_i));
  assert_store_kills_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && !flush_i && !ins_valid_i) |=> ((valid_q & $past(st_hit)) == '0));
  assert_insert_lives_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !flush_i) |=> valid_q[$past(ins_slot)]);
  assert_unique_reg_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chk_hit) && $onehot0(ins_hit));
  assert_rr_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rr_q <= LAST);
endmodule

// File: tb/spec_ld_check_table_bench.sv
module spec_ld_check_table_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int AW = 8;
  localparam int RW = 3;
  localparam int G = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic flush = 0, iv = 0, sv = 0, cv = 0, ck = 0;
  logic [RW-1:0] ir = '0, cr = '0;
  logic [AW-1:0] ia = '0, sa = '0;
  logic ok, fail;

  int total = 0, bad = 0;
  bit m_v [N];
  int m_r [N];
  int m_l [N];
  int m_rr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_ld_check_table #(.NUM_ENTRIES(N), .ADDR_W(AW), .REG_W(RW), .GRAN_LG2(G))
  u_spec_ld_check_table (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .ins_valid_i(iv), .ins_reg_i(ir), .ins_addr_i(ia),
    .st_valid_i(sv), .st_addr_i(sa),
    .chk_valid_i(cv), .chk_reg_i(cr), .chk_keep_i(ck),
    .chk_ok_o(ok), .chk_fail_o(fail));

  task automatic step(input bit f, input bit i_v, input int i_r, input int i_a,
                      input bit s_v, input int s_a, input bit c_v, input int c_r,
                      input bit c_k, input int exp, input string tag);
    int hit, slot;
    bit eok, evict;
    @(negedge clk);
    flush = f; iv = i_v; ir = RW'(i_r); ia = AW'(i_a);
    sv = s_v; sa = AW'(s_a); cv = c_v; cr = RW'(c_r); ck = c_k;
    #1;
    hit = -1;
    for (int j = 0; j < N; j++) if (m_v[j] && m_r[j] == c_r) hit = j;
    eok = c_v && (hit >= 0);
    total++;
    if (ok !== eok || fail !== (c_v && hit < 0)) begin
      bad++;
      $display("FAIL %s model: ok=%b fail=%b expected ok=%b", tag, ok, fail, eok);
    end
    if (exp >= 0) begin
      total++;
      if (ok !== exp[0]) begin
        bad++;
        $display("FAIL %s: ok=%b expected %0d", tag, ok, exp);
      end
    end
    slot = -1; evict = 0;
    for (int j = N - 1; j >= 0; j--) if (!m_v[j]) slot = j;
    for (int j = 0; j < N; j++) if (m_v[j] && m_r[j] == i_r) slot = j;
    if (slot < 0) begin slot = m_rr; evict = 1; end
    @(posedge clk);
    if (f) begin
      for (int j = 0; j < N; j++) m_v[j] = 0;
    end else begin
      if (eok && !c_k) m_v[hit] = 0;
      if (s_v) for (int j = 0; j < N; j++) if (m_l[j] == (s_a >> G)) m_v[j] = 0;
      if (i_v) begin
        m_v[slot] = 1; m_r[slot] = i_r; m_l[slot] = i_a >> G;
        if (evict) m_rr = (m_rr + 1) % N;
      end
    end
  endtask

  task automatic ins(input int r, input int a);
    step(0, 1, r, a, 0, 0, 0, 0, 0, -1, "ins");
  endtask
  task automatic st(input int a);
    step(0, 0, 0, 0, 1, a, 0, 0, 0, -1, "st");
  endtask
  task automatic chk(input int r, input bit k, input int e, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, r, k, e, tag);
  endtask
  task automatic do_flush();
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, -1, "flush");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: ok=x expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int j = 0; j < N; j++) begin m_v[j] = 0; m_r[j] = 0; m_l[j] = 0; end
    #(CLK_PERIOD * 3);
    rst_n = 1;
    // R1 reset state
    for (int r = 0; r < 8; r++) chk(r, 1, 0, "R1 reset empty");
    // R3 outputs low when idle
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 idle");
    total++;
    if (fail !== 1'b0) begin bad++; $display("FAIL R3 idle fail=%b expected 0", fail); end
    // R2 / R4
    ins(1, 8'h10);
    chk(1, 1, 1, "R2 insert hit");
    chk(1, 1, 1, "R4 keep retains");
    chk(1, 0, 1, "R4 remove hit");
    chk(1, 1, 0, "R4 removed");
    // R5 / R6 sweep of store addresses against one entry
    for (int a = 0; a < 256; a++) begin
      do_flush();
      ins(1, 8'h48);
      ins(2, 8'hC0);
      st(a);
      chk(1, 1, ((a >> 3) != 9) ? 1 : 0, "R6 granularity");
      chk(2, 1, ((a >> 3) != 24) ? 1 : 0, "R5 other entry");
    end
    // R7 overwrite
    do_flush();
    ins(4, 8'h40);
    ins(4, 8'h50);
    st(8'h40);
    chk(4, 1, 1, "R7 old address dropped");
    st(8'h57);
    chk(4, 1, 0, "R7 new address live");
    // R10 single entry per register: remove once, then gone
    ins(5, 8'h60); ins(5, 8'h70);
    chk(5, 0, 1, "R10 one entry");
    chk(5, 1, 0, "R10 no duplicate");
    // R8 eviction order
    do_flush();
    for (int r = 0; r < 4; r++) ins(r, r * 16);
    ins(4, 8'h80);
    ins(5, 8'h90);
    chk(0, 1, 0, "R8 evict slot0");
    chk(1, 1, 0, "R8 evict slot1");
    for (int r = 2; r < 6; r++) chk(r, 1, 1, "R8 survivors");
    ins(6, 8'hA0);
    chk(2, 1, 0, "R8 evict slot2");
    // R9 same-cycle store and insert
    do_flush();
    step(0, 1, 3, 8'h33, 1, 8'h30, 0, 0, 0, -1, "R9 st+ins");
    chk(3, 1, 1, "R9 insert wins");
    step(0, 1, 3, 8'h33, 0, 0, 1, 3, 0, 1, "R9 chk+ins");
    chk(3, 1, 1, "R9 insert wins over removal");
    // R1 flush beats insert
    step(1, 1, 6, 8'h66, 0, 0, 0, 0, 0, -1, "R1 flush+ins");
    chk(6, 1, 0, "R1 flush overrides insert");
    chk(3, 1, 0, "R1 flush empties");
    // random interleaving against the model
    for (int k = 0; k < 4000; k++) begin
      step(($urandom % 64) == 0, $urandom % 2, $urandom % 8, $urandom % 64,
           $urandom % 3 == 0, $urandom % 64, $urandom % 2, $urandom % 8,
           $urandom % 2, -1, "R2 R4 R5 R8 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule